// File: doc/BRIEF.md
# Blinking Colour Dot Grid Renderer

This block paints a grid of coloured rectangles onto a VGA raster that runs on a coarse pixel clock. The grid has eight columns and six rows. An external timing generator supplies four things: the visible flag, the cycle count within the line, the number of the visible line, and a one-cycle pulse once per frame. From these the block decides, in the same cycle, whether the raster sits inside a dot or in one of the black gaps between dots. It then drives a 3-bit RGB value: black in a gap or outside the active area, otherwise the stored colour of that dot.

The block also makes the grid blink. A 16-bit linear feedback shift register steps once per frame. A frame countdown loaded from that register sets a pseudo-random gap of 22 to 38 frames between events, which at 60 frames per second is about 0.36 s to 0.63 s. When the countdown expires, the register picks one of the 48 dots and a new non-black colour for it. Colour writes take effect only on the frame pulse, so the picture never tears within a frame.

Top module: `dot_grid_blinker`

## Requirements
- R1: Horizontally the grid repeats every 14 cycles from cycle 0. Within each 14-cycle pitch, offsets 0 to 11 belong to the dot and offsets 12 and 13 are black. There are 8 columns, and any cycle at or beyond 112 is black.
- R2: Vertically the grid repeats every 80 visible lines from line 0. Within each 80-line row, lines 0 to 67 belong to the dot and lines 68 to 79 are black. There are 6 rows, and any line at or beyond 480 is black.
- R3: Dot index equals row*8 + column. Inside a dot, `rgb` shows that dot's stored colour in the same cycle as the raster inputs, with no register delay.
- R4: When `vis` is low, `rgb` is 3'b000 whatever the raster position.
- R5: After reset, dot i holds colour (i mod 7) + 1, which cycles through the seven non-black codes.
- R6: A frame counter starts at 22 + (seed mod 17) = 28. Each `frame_start` pulse decrements it. The pulse that finds it at 1 is a blink event, and that pulse reloads the counter with 22 + (L mod 17), where L is the register value before the step.
- R7: The random register resets to 16'hACE1. On each `frame_start` pulse, and at no other time, it shifts left, with the new bit 0 equal to bit15 ^ bit13 ^ bit12 ^ bit10. It is never zero.
- R8: Stored dot colours change only on a clock edge at which `frame_start` is high.
- R9: On a blink event, dot (L mod 48) takes colour (L[15:8] mod 7) + 1, so a dot is never black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse per frame, given during blanking |
| vis | input | 1 | High while the raster is in the visible area |
| hpos | input | 8 | Cycle index within the line |
| vline | input | 9 | Visible line number, 0 to 479 |
| rgb | output | 3 | Colour code: bit 2 red, bit 1 green, bit 0 blue |

## Verification
The checks assume that `frame_start` is a single-cycle pulse that arrives while `vis` is low. Each pulse advances the blink state by exactly one frame, so the checks also assume that the raster inputs have settled by the time `rgb` is sampled. The stimulus pulses `frame_start` only in a cycle with `vis` held low, and then drops it for the following cycles. It draws raster positions from the whole input range, so that coordinates past the grid and gap offsets are included, and it also samples one point inside every dot after every frame.

// File: rtl/dot_grid_blinker.sv
module dot_grid_blinker #(
  parameter int COLS    = 8,
  parameter int ROWS    = 6,
  parameter int DOT_W   = 12,
  parameter int GAP_W   = 2,
  parameter int DOT_H   = 68,
  parameter int GAP_H   = 12,
  parameter int HW      = 8,
  parameter int VW      = 9,
  parameter int MIN_FR  = 22,
  parameter int SPAN_FR = 17,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          vis,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vline,
  output logic [2:0]    rgb
);
  localparam int NDOTS   = COLS * ROWS;
  localparam int PITCH_W = DOT_W + GAP_W;
  localparam int PITCH_H = DOT_H + GAP_H;
  localparam int HEND    = COLS * PITCH_W;
  localparam int VEND    = ROWS * PITCH_H;
  localparam int IW      = $clog2(NDOTS);
  localparam int CW      = $clog2(MIN_FR + SPAN_FR);
  localparam int CMAX    = MIN_FR + SPAN_FR - 1;
  localparam logic [CW-1:0] CNT0 = CW'(MIN_FR + int'(SEED) % SPAN_FR);

  logic [15:0]        lfsr;
  logic [CW-1:0]      cnt;
  logic [NDOTS*3-1:0] colours;

  logic [HW-1:0] hcol, hin;
  logic [VW-1:0] vrow, vin;
  logic          h_on, v_on;
  logic [IW-1:0] idx;

  assign hcol = hpos / HW'(PITCH_W);
  assign hin  = hpos % HW'(PITCH_W);
  assign vrow = vline / VW'(PITCH_H);
  assign vin  = vline % VW'(PITCH_H);
  assign h_on = (int'(hpos) < HEND) && (int'(hin) < DOT_W);
  assign v_on = (int'(vline) < VEND) && (int'(vin) < DOT_H);
  assign idx  = IW'(int'(vrow) * COLS + int'(hcol));
  assign rgb  = (vis && h_on && v_on) ? colours[int'(idx)*3 +: 3] : 3'd0;

  logic          fb;
  logic [IW-1:0] pick;
  logic [2:0]    new_col;
  logic [CW-1:0] reload;

  assign fb      = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  assign pick    = IW'(int'(lfsr) % NDOTS);
  assign new_col = 3'(int'(lfsr[15:8]) % 7 + 1);
  assign reload  = CW'(MIN_FR + int'(lfsr) % SPAN_FR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= SEED;
      cnt  <= CNT0;
      for (int i = 0; i < NDOTS; i++) colours[i*3 +: 3] <= 3'(i % 7 + 1);
    end else if (frame_start) begin
      lfsr <= {lfsr[14:0], fb};
      if (cnt == CW'(1)) begin
        colours[int'(pick)*3 +: 3] <= new_col;
        cnt <= reload;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dot_grid_blinker_chk.sv
module dot_grid_blinker_chk #(
  parameter int NDOTS = 48,
  parameter int HW    = 8,
  parameter int HEND  = 112,
  parameter int CW    = 6,
  parameter int CMAX  = 38
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               vis,
  input logic [HW-1:0]      hpos,
  input logic [2:0]         rgb,
  input logic [15:0]        lfsr,
  input logic [CW-1:0]      cnt,
  input logic [NDOTS*3-1:0] colours
);
  a_r4_dark_when_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    !vis |-> rgb == 3'd0);
  a_r1_dark_past_grid: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hpos) >= HEND |-> rgb == 3'd0);
  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'd0);
  a_r7_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(lfsr));
  a_r8_colours_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(colours));
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= CW'(1) && int'(cnt) <= CMAX);
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && cnt != CW'(1) |=> cnt == $past(cnt) - CW'(1));
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NDOTS; i++)
        a_r9_never_black: assert (colours[i*3 +: 3] != 3'd0);
    end
  end
endmodule

bind dot_grid_blinker dot_grid_blinker_chk #(
  .NDOTS(NDOTS), .HW(HW), .HEND(HEND), .CW(CW), .CMAX(CMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vis(vis),
  .hpos(hpos), .rgb(rgb), .lfsr(lfsr), .cnt(cnt), .colours(colours)
);

// File: tb/dot_grid_blinker_bench.sv
module dot_grid_blinker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       vis = 1'b0;
  logic [7:0] hpos = '0;
  logic [8:0] vline = '0;
  logic [2:0] rgb;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0]  mcol [48];
  logic [15:0] ml;
  int          mcnt;
  int          events = 0;

  always #2 clk = ~clk;

  dot_grid_blinker u_dot_grid_blinker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vis(vis),
    .hpos(hpos), .vline(vline), .rgb(rgb)
  );

  // R7: shift left, new bit 0 from bits 15, 13, 12 and 10
  function automatic logic [15:0] lfsr_next(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [2:0] exp_px(bit v, int h, int y);
    if (!v) return 3'd0;
    if (h >= 112 || y >= 480) return 3'd0;
    if (h % 14 >= 12 || y % 80 >= 68) return 3'd0;
    return mcol[(y / 80) * 8 + h / 14];
  endfunction

  task automatic chk(string tag, bit v, int h, int y);
    logic [2:0] e;
    @(negedge clk);
    vis = v; hpos = 8'(h); vline = 9'(y);
    #1;
    e = exp_px(v, h, y);
    checks++;
    if (rgb !== e) begin
      fails++;
      $display("FAIL %s vis=%0d h=%0d y=%0d rgb=%0d expected=%0d", tag, v, h, y, rgb, e);
    end
  endtask

  // R6 R9: model one frame pulse, returns 1 on a blink event
  task automatic frame(output bit ev);
    @(negedge clk);
    vis = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    ev = 0;
    if (mcnt == 1) begin
      mcol[int'(ml) % 48] = 3'(int'(ml[15:8]) % 7 + 1);
      mcnt = 22 + int'(ml) % 17;
      ev = 1;
      events++;
    end else begin
      mcnt--;
    end
    ml = lfsr_next(ml);
  endtask

  initial begin
    int unused;
    bit ev;
    unused = $urandom(32'd4242);
    ml = 16'hACE1;
    mcnt = 22 + 16'hACE1 % 17;
    for (int i = 0; i < 48; i++) mcol[i] = 3'(i % 7 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset pattern and geometry corners
    chk("R5", 1, 0, 0);
    chk("R5", 1, 7 * 14 + 5, 5 * 80 + 10);
    chk("R5", 1, 3 * 14, 2 * 80);
    chk("R1", 1, 11, 0);
    chk("R1", 1, 12, 0);
    chk("R1", 1, 13, 0);
    chk("R1", 1, 109, 0);
    chk("R1", 1, 110, 0);
    chk("R1", 1, 112, 0);
    chk("R1", 1, 159, 100);
    chk("R2", 1, 0, 67);
    chk("R2", 1, 0, 68);
    chk("R2", 1, 0, 79);
    chk("R2", 1, 0, 80);
    chk("R2", 1, 20, 479);
    chk("R2", 1, 20, 480);
    chk("R2", 1, 20, 511);
    chk("R4", 0, 0, 0);
    chk("R4", 0, 50, 170);
    chk("R3", 1, 14 * 2 + 4, 80 * 1 + 30);

    for (int f = 0; f < 320; f++) begin
      frame(ev);
      // R8: every dot read back after each frame pulse
      for (int d = 0; d < 48; d++)
        chk(ev ? "R6/R7/R9" : "R8", 1, (d % 8) * 14 + int'($urandom % 12),
            (d / 8) * 80 + int'($urandom % 68));
      for (int k = 0; k < 8; k++)
        chk("R3/R4", ($urandom % 5) != 0, int'($urandom % 256), int'($urandom % 512));
      // R8: hold without pulse, colours must not move
      chk("R8", 1, 6, 6);
    end

    checks++;
    if (events < 5) begin
      fails++;
      $display("FAIL R6 events=%0d expected>=5", events);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule